// File: doc/BRIEF.md
# Initial Flow-Control Packet Engine

This block runs the credit-initialisation handshake of a serial link's data-link layer once the physical link reports that it is up. It advertises the local receive credits for three traffic classes (posted requests, non-posted requests and completions). Each advertisement is a short framed packet on a 16-bit stream that carries two 8-bit symbols per clock. Every packet holds a 4-byte body protected by a 16-bit CRC. The packet opens with a start-of-packet control symbol and closes with an end control symbol.

Advertising runs in two rounds. In the first round the engine sends a triple of first-round packets (posted, then non-posted, then completion) and repeats it back to back. It stops repeating once the partner has delivered a valid packet of either round for every class. The engine then sends one triple of second-round packets and raises its flow-control-initialised flag. At the same time it decodes the partner's incoming packets, checks their framing and CRC, and holds the partner's credit values for each class. The local credit values come either from parameter defaults or from configuration inputs.

Top module: `fcinit_engine`

## Requirements
- R1: Under synchronous reset `rst`, or while `link_up` is low, the transmit stream is idle (`tx_data` = 0x0000, `tx_k` = 00), `fc_init` is low and all six `peer_*` outputs are zero.
- R2: On the first clock edge that samples `link_up` high, transmission starts, so the first start symbol is present right after that edge. Each packet takes 4 clocks and 8 symbols. The first symbol in time sits in `tx_data[7:0]` with `tx_k[0]`, and the second sits in `tx_data[15:8]` with `tx_k[1]`. The symbol order is start (control, 0x5C), type, B1, B2, B3, C0, C1, end (control, 0xFD). Data symbols have their K flag low.
- R3: The body is type, B1 = {00, hdr[7:2]}, B2 = {hdr[1:0], 00, data[11:8]}, B3 = data[7:0], where hdr is 8 bits and data is 12 bits. Type is 0x40/0x50/0x60 for first-round posted/non-posted/completion and 0xC0/0xD0/0xE0 for the second round.
- R4: The CRC register starts at 0xFFFF. It takes the type, B1, B2 and B3 bytes in that order, each byte from bit 0 to bit 7. For each bit, fb = crc[15] xor bit, and crc = (crc << 1) xor (fb ? 0x100B : 0). With f = ~crc, C0[i] = f[15-i] and C1[i] = f[7-i].
- R5: First-round triples (posted, non-posted, completion) go out back to back. A second-round triple starts only at a triple boundary, and only once a valid packet of either round has been received for all three classes.
- R6: Exactly one second-round triple is sent. On the edge after its last beat, `fc_init` goes high and the stream returns to idle, and both stay that way while `link_up` stays high.
- R7: With `cfg_use` = 0 the advertised credits are the defaults: posted 4/64, non-posted 4/0, completion 4/64 (header/data). With `cfg_use` = 1 they are the `cfg_*` inputs.
- R8: A received packet that starts with 0x5C as a control symbol in the low lane and passes all of the following checks updates the `peer_*` credits of its class on the edge of its last beat. The checks are: end symbol 0xFD as a control symbol in the high lane of the fourth beat, matching CRC, a type from either round, and zero reserved bits. This applies to packets of both rounds.
- R9: A received packet with a wrong CRC or a missing end symbol is dropped and leaves every `peer_*` output unchanged.
- R10: A drop of `link_up` clears the partner credits, the received-class record and `fc_init` on the next edge, and the handshake restarts from the first round when the link returns.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| link_up | input | 1 | Physical link ready; starts and holds the handshake |
| cfg_use | input | 1 | 1 selects the cfg_* credit inputs, 0 the defaults |
| cfg_p_hdr | input | 8 | Posted header credits |
| cfg_p_data | input | 12 | Posted data credits |
| cfg_np_hdr | input | 8 | Non-posted header credits |
| cfg_np_data | input | 12 | Non-posted data credits |
| cfg_cpl_hdr | input | 8 | Completion header credits |
| cfg_cpl_data | input | 12 | Completion data credits |
| rx_data | input | 16 | Received symbols, first in time in bits [7:0] |
| rx_k | input | 2 | Control flags for the two received symbols |
| tx_data | output | 16 | Transmitted symbols, first in time in bits [7:0] |
| tx_k | output | 2 | Control flags for the two transmitted symbols |
| fc_init | output | 1 | Flow-control initialisation complete |
| peer_p_hdr | output | 8 | Partner posted header credits |
| peer_p_data | output | 12 | Partner posted data credits |
| peer_np_hdr | output | 8 | Partner non-posted header credits |
| peer_np_data | output | 12 | Partner non-posted data credits |
| peer_cpl_hdr | output | 8 | Partner completion header credits |
| peer_cpl_data | output | 12 | Partner completion data credits |

## Verification
The assertions check the following on every cycle:
- The stream goes quiet and the partner credits clear after a link drop.
- A start symbol is followed by exactly two data beats and then the end beat.
- A second-round packet never starts before all three classes have been heard.
- `fc_init` rises only right after an end beat and then holds.
- A rejected incoming frame leaves the partner credits untouched.

The exact byte content of each packet, the CRC values, the default versus configured credit selection, the number of repeated first-round triples and the credit values decoded from the partner can only be shown by the bench's scenarios. There, the bench rebuilds every expected packet with its own encoder and compares it symbol by symbol.

// File: rtl/fcinit_pkg.sv
package fcinit_pkg;
  localparam int HDR_W  = 8;
  localparam int DATA_W = 12;
  localparam int NCLS   = 3;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int CLS_W  = 2;

  localparam logic [7:0]  SYM_SDP  = 8'h5C;
  localparam logic [7:0]  SYM_END  = 8'hFD;
  localparam logic [15:0] CRC_POLY = 16'h100B;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  typedef enum logic [1:0] {PH_IDLE, PH_FC1, PH_FC2, PH_DONE} phase_e;

  // round 1 -> 0x40 + 0x10*class, round 2 -> 0xC0 + 0x10*class
  function automatic logic [7:0] fc_type(input logic round2, input logic [CLS_W-1:0] cls);
    return {round2, 1'b1, cls, 4'h0};
  endfunction

  function automatic logic [31:0] fc_body(input logic [7:0] typ,
                                          input logic [HDR_W-1:0] hdr,
                                          input logic [DATA_W-1:0] dat);
    return {typ, 2'b00, hdr[7:2], hdr[1:0], 2'b00, dat[11:8], dat[7:0]};
  endfunction

  // returns {C0, C1}, each already bit-reversed and inverted
  function automatic logic [15:0] fc_crc16(input logic [31:0] body);
    logic [15:0] c;
    logic [15:0] f;
    logic [15:0] o;
    logic        fb;
    c = CRC_SEED;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[15] ^ body[24 - 8*i + j];
        c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
      end
    end
    f = ~c;
    for (int k = 0; k < 8; k++) begin
      o[8+k] = f[15-k];
      o[k]   = f[7-k];
    end
    return o;
  endfunction
endpackage

// File: rtl/fcinit_tx.sv
module fcinit_tx
  import fcinit_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              link_up,
  input  logic                              all_seen,
  input  logic [NCLS-1:0][HDR_W-1:0]        loc_hdr,
  input  logic [NCLS-1:0][DATA_W-1:0]       loc_dat,
  output logic [15:0]                       tx_data,
  output logic [1:0]                        tx_k,
  output logic                              fc_init
);
  localparam logic [CLS_W-1:0]  LAST_CLS  = CLS_W'(NCLS - 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  phase_e             phase;
  logic [CLS_W-1:0]   cls;
  logic [BEAT_W-1:0]  beat;
  logic               sending;
  logic [31:0]        body;
  logic [15:0]        crc;

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      phase <= PH_IDLE;
      cls   <= '0;
      beat  <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          phase <= PH_FC1;
          cls   <= '0;
          beat  <= '0;
        end
        PH_FC1, PH_FC2: begin
          if (beat != LAST_BEAT) begin
            beat <= beat + 1'b1;
          end else begin
            beat <= '0;
            if (cls != LAST_CLS) begin
              cls <= cls + 1'b1;
            end else begin
              cls <= '0;
              if (phase == PH_FC2)  phase <= PH_DONE;
              else if (all_seen)    phase <= PH_FC2;
            end
          end
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  assign sending = (phase == PH_FC1) || (phase == PH_FC2);
  assign fc_init = (phase == PH_DONE);

  always_comb begin
    body = fc_body(fc_type(phase == PH_FC2, cls), loc_hdr[cls], loc_dat[cls]);
    crc  = fc_crc16(body);
    tx_data = 16'h0000;
    tx_k    = 2'b00;
    if (sending) begin
      case (beat)
        2'd0:    begin tx_data = {body[31:24], SYM_SDP}; tx_k = 2'b01; end
        2'd1:    begin tx_data = {body[15:8], body[23:16]}; end
        2'd2:    begin tx_data = {crc[15:8], body[7:0]}; end
        default: begin tx_data = {SYM_END, crc[7:0]}; tx_k = 2'b10; end
      endcase
    end
  end
endmodule

// File: rtl/fcinit_rx.sv
module fcinit_rx
  import fcinit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 link_up,
  input  logic [15:0]          rx_data,
  input  logic [1:0]           rx_k,
  output logic                 frame_ok,
  output logic                 frame_bad,
  output logic [CLS_W-1:0]     frame_cls,
  output logic [HDR_W-1:0]     frame_hdr,
  output logic [DATA_W-1:0]    frame_dat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic               busy;
  logic [BEAT_W-1:0]  beat;
  logic [39:0]        held;   // type, B1, B2, B3, C0
  logic               last_beat;
  logic               end_ok;
  logic               crc_ok;
  logic               type_ok;

  always_ff @(posedge clk) begin
    if (rst || !link_up) begin
      busy <= 1'b0;
      beat <= '0;
      held <= '0;
    end else if (!busy) begin
      if (rx_k == 2'b01 && rx_data[7:0] == SYM_SDP) begin
        busy          <= 1'b1;
        beat          <= 2'd1;
        held[39:32]   <= rx_data[15:8];
      end
    end else begin
      case (beat)
        2'd1: begin held[31:16] <= {rx_data[7:0], rx_data[15:8]}; beat <= 2'd2; end
        2'd2: begin held[15:0]  <= {rx_data[7:0], rx_data[15:8]}; beat <= LAST_BEAT; end
        default: begin busy <= 1'b0; beat <= '0; end
      endcase
    end
  end

  assign last_beat = busy && (beat == LAST_BEAT);
  assign end_ok    = (rx_k == 2'b10) && (rx_data[15:8] == SYM_END);
  assign crc_ok    = (fc_crc16(held[39:8]) == {held[7:0], rx_data[7:0]});
  assign type_ok   = (held[38] == 1'b1) && (held[39] | held[38]) &&
                     (held[37:36] != 2'b11) && (held[35:32] == 4'h0) &&
                     (held[31:30] == 2'b00) && (held[21:20] == 2'b00);

  assign frame_ok  = last_beat && end_ok && crc_ok && type_ok;
  assign frame_bad = last_beat && !(end_ok && crc_ok);
  assign frame_cls = held[37:36];
  assign frame_hdr = {held[29:24], held[23:22]};
  assign frame_dat = {held[19:16], held[15:8]};
endmodule

// File: rtl/fcinit_store.sv
module fcinit_store
  import fcinit_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          link_up,
  input  logic                          upd,
  input  logic [CLS_W-1:0]              upd_cls,
  input  logic [HDR_W-1:0]              upd_hdr,
  input  logic [DATA_W-1:0]             upd_dat,
  output logic [NCLS-1:0][HDR_W-1:0]    peer_hdr,
  output logic [NCLS-1:0][DATA_W-1:0]   peer_dat,
  output logic                          all_seen
);
  logic [NCLS-1:0] seen;

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst || !link_up) begin
        seen[g]     <= 1'b0;
        peer_hdr[g] <= '0;
        peer_dat[g] <= '0;
      end else if (upd && upd_cls == CLS_W'(g)) begin
        seen[g]     <= 1'b1;
        peer_hdr[g] <= upd_hdr;
        peer_dat[g] <= upd_dat;
      end
    end
  end

  assign all_seen = &seen;
endmodule

// File: rtl/fcinit_engine.sv
module fcinit_engine
  import fcinit_pkg::*;
#(
  parameter logic [HDR_W-1:0]  DEF_P_HDR    = 8'd4,
  parameter logic [DATA_W-1:0] DEF_P_DATA   = 12'd64,
  parameter logic [HDR_W-1:0]  DEF_NP_HDR   = 8'd4,
  parameter logic [DATA_W-1:0] DEF_NP_DATA  = 12'd0,
  parameter logic [HDR_W-1:0]  DEF_CPL_HDR  = 8'd4,
  parameter logic [DATA_W-1:0] DEF_CPL_DATA = 12'd64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              link_up,
  input  logic              cfg_use,
  input  logic [7:0]        cfg_p_hdr,
  input  logic [11:0]       cfg_p_data,
  input  logic [7:0]        cfg_np_hdr,
  input  logic [11:0]       cfg_np_data,
  input  logic [7:0]        cfg_cpl_hdr,
  input  logic [11:0]       cfg_cpl_data,
  input  logic [15:0]       rx_data,
  input  logic [1:0]        rx_k,
  output logic [15:0]       tx_data,
  output logic [1:0]        tx_k,
  output logic              fc_init,
  output logic [7:0]        peer_p_hdr,
  output logic [11:0]       peer_p_data,
  output logic [7:0]        peer_np_hdr,
  output logic [11:0]       peer_np_data,
  output logic [7:0]        peer_cpl_hdr,
  output logic [11:0]       peer_cpl_data
);
  logic [NCLS-1:0][HDR_W-1:0]  loc_hdr;
  logic [NCLS-1:0][DATA_W-1:0] loc_dat;
  logic [NCLS-1:0][HDR_W-1:0]  pr_hdr;
  logic [NCLS-1:0][DATA_W-1:0] pr_dat;
  logic                        all_seen;
  logic                        frame_ok;
  logic                        frame_bad;
  logic [CLS_W-1:0]            frame_cls;
  logic [HDR_W-1:0]            frame_hdr;
  logic [DATA_W-1:0]           frame_dat;

  always_comb begin
    if (cfg_use) begin
      loc_hdr = {cfg_cpl_hdr,  cfg_np_hdr,  cfg_p_hdr};
      loc_dat = {cfg_cpl_data, cfg_np_data, cfg_p_data};
    end else begin
      loc_hdr = {DEF_CPL_HDR,  DEF_NP_HDR,  DEF_P_HDR};
      loc_dat = {DEF_CPL_DATA, DEF_NP_DATA, DEF_P_DATA};
    end
  end

  fcinit_tx u_tx (
    .clk(clk), .rst(rst), .link_up(link_up), .all_seen(all_seen),
    .loc_hdr(loc_hdr), .loc_dat(loc_dat),
    .tx_data(tx_data), .tx_k(tx_k), .fc_init(fc_init)
  );

  fcinit_rx u_rx (
    .clk(clk), .rst(rst), .link_up(link_up), .rx_data(rx_data), .rx_k(rx_k),
    .frame_ok(frame_ok), .frame_bad(frame_bad), .frame_cls(frame_cls),
    .frame_hdr(frame_hdr), .frame_dat(frame_dat)
  );

  fcinit_store u_store (
    .clk(clk), .rst(rst), .link_up(link_up),
    .upd(frame_ok), .upd_cls(frame_cls), .upd_hdr(frame_hdr), .upd_dat(frame_dat),
    .peer_hdr(pr_hdr), .peer_dat(pr_dat), .all_seen(all_seen)
  );

  assign peer_p_hdr    = pr_hdr[0];
  assign peer_p_data   = pr_dat[0];
  assign peer_np_hdr   = pr_hdr[1];
  assign peer_np_data  = pr_dat[1];
  assign peer_cpl_hdr  = pr_hdr[2];
  assign peer_cpl_data = pr_dat[2];
endmodule

// File: rtl/fcinit_engine_chk.sv
module fcinit_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        link_up,
  input logic [15:0] tx_data,
  input logic [1:0]  tx_k,
  input logic        fc_init,
  input logic        all_seen,
  input logic        frame_bad,
  input logic [7:0]  peer_p_hdr,
  input logic [11:0] peer_p_data,
  input logic [7:0]  peer_np_hdr,
  input logic [11:0] peer_np_data,
  input logic [7:0]  peer_cpl_hdr,
  input logic [11:0] peer_cpl_data
);
  // R1
  idle_when_down_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (tx_k == 2'b00 && tx_data == 16'h0000 && !fc_init));

  // R2
  frame_shape_chk: assert property (@(posedge clk) disable iff (rst || !link_up)
    (tx_k == 2'b01) |=> (tx_k == 2'b00) ##1 (tx_k == 2'b00) ##1 (tx_k == 2'b10));

  // R5
  round2_after_peer_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_k == 2'b01 && tx_data[15]) |-> all_seen);

  // R6
  init_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fc_init) |-> ($past(tx_k) == 2'b10));

  // R6
  init_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (fc_init && link_up) |=> fc_init);

  // R9
  bad_frame_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_bad && link_up) |=> ($stable(peer_p_hdr) && $stable(peer_p_data) &&
                                $stable(peer_np_hdr) && $stable(peer_np_data) &&
                                $stable(peer_cpl_hdr) && $stable(peer_cpl_data)));

  // R10
  cleared_when_down_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> (peer_p_hdr == 8'h0 && peer_p_data == 12'h0 &&
                  peer_np_hdr == 8'h0 && peer_np_data == 12'h0 &&
                  peer_cpl_hdr == 8'h0 && peer_cpl_data == 12'h0));
endmodule

bind fcinit_engine fcinit_engine_chk u_chk (
  .clk(clk), .rst(rst), .link_up(link_up), .tx_data(tx_data), .tx_k(tx_k),
  .fc_init(fc_init), .all_seen(all_seen), .frame_bad(frame_bad),
  .peer_p_hdr(peer_p_hdr), .peer_p_data(peer_p_data),
  .peer_np_hdr(peer_np_hdr), .peer_np_data(peer_np_data),
  .peer_cpl_hdr(peer_cpl_hdr), .peer_cpl_data(peer_cpl_data)
);

// File: tb/sim_fcinit_engine.sv
module sim_fcinit_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, link_up, cfg_use;
  logic [7:0]  cfg_p_hdr, cfg_np_hdr, cfg_cpl_hdr;
  logic [11:0] cfg_p_data, cfg_np_data, cfg_cpl_data;
  logic [15:0] rx_data, tx_data;
  logic [1:0]  rx_k, tx_k;
  logic        fc_init;
  logic [7:0]  peer_p_hdr, peer_np_hdr, peer_cpl_hdr;
  logic [11:0] peer_p_data, peer_np_data, peer_cpl_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcinit_engine u0 (
    .clk(clk), .rst(rst), .link_up(link_up), .cfg_use(cfg_use),
    .cfg_p_hdr(cfg_p_hdr), .cfg_p_data(cfg_p_data),
    .cfg_np_hdr(cfg_np_hdr), .cfg_np_data(cfg_np_data),
    .cfg_cpl_hdr(cfg_cpl_hdr), .cfg_cpl_data(cfg_cpl_data),
    .rx_data(rx_data), .rx_k(rx_k), .tx_data(tx_data), .tx_k(tx_k), .fc_init(fc_init),
    .peer_p_hdr(peer_p_hdr), .peer_p_data(peer_p_data),
    .peer_np_hdr(peer_np_hdr), .peer_np_data(peer_np_data),
    .peer_cpl_hdr(peer_cpl_hdr), .peer_cpl_data(peer_cpl_data)
  );

  typedef struct packed {
    logic        use_cfg;
    logic [7:0]  ph;  logic [11:0] pd;
    logic [7:0]  nh;  logic [11:0] nd;
    logic [7:0]  ch;  logic [11:0] cd;
    logic [1:0]  extra;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 8'd9,   12'd100,  8'd7, 12'd3,   8'd2,   12'd5,    2'd0},
    '{1'b1, 8'd16,  12'd256,  8'd1, 12'd0,   8'd255, 12'hFFF,  2'd1},
    '{1'b1, 8'd0,   12'd0,    8'd0, 12'd0,   8'd0,   12'd0,    2'd2},
    '{1'b0, 8'hFF,  12'hABC,  8'h5A, 12'h123, 8'h81, 12'h800,  2'd0}
  };

  logic [7:0]  exp_hdr [3];
  logic [11:0] exp_dat [3];

  // bench encoder: taps of x^16+x^12+x^3+x+1 written out bit by bit
  function automatic logic [63:0] mk_pkt(input logic [7:0] typ, input logic [7:0] h,
                                         input logic [11:0] d);
    logic [7:0]  bb [4];
    logic [15:0] c, n, f;
    logic [7:0]  c0, c1;
    logic        fb;
    bb[0] = typ;
    bb[1] = {2'b00, h[7:2]};
    bb[2] = {h[1:0], 2'b00, d[11:8]};
    bb[3] = d[7:0];
    c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      fb    = c[15] ^ bb[i/8][i%8];
      n     = {c[14:0], 1'b0};
      n[0]  = fb;
      n[1]  = c[0] ^ fb;
      n[3]  = c[2] ^ fb;
      n[12] = c[11] ^ fb;
      c = n;
    end
    f = ~c;
    for (int i = 0; i < 8; i++) begin
      c0[i] = f[15-i];
      c1[i] = f[7-i];
    end
    return {8'hFD, c1, c0, bb[3], bb[2], bb[1], typ, 8'h5C};
  endfunction

  function automatic logic [7:0] typ_of(input bit r2, input int cls);
    return (r2 ? 8'hC0 : 8'h40) + 8'(cls * 16);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic grab(output logic [63:0] syms, output logic [7:0] kp, output int waited);
    bit found = 0;
    waited = 0;
    syms = '0;
    kp = '0;
    while (!found && waited < 100) begin
      @(negedge clk);
      waited++;
      if (tx_k == 2'b01 && tx_data[7:0] == 8'h5C) found = 1;
    end
    syms[15:0] = tx_data;
    kp[1:0]    = tx_k;
    for (int b = 1; b < 4; b++) begin
      @(negedge clk);
      syms[16*b +: 16] = tx_data;
      kp[2*b +: 2]     = tx_k;
    end
  endtask

  task automatic cmp_pkt(input logic [63:0] syms, input logic [7:0] kp,
                         input bit r2, input int cls, input string req);
    logic [63:0] e;
    e = mk_pkt(typ_of(r2, cls), exp_hdr[cls], exp_dat[cls]);
    chk(syms == e, req, "packet symbols", syms, e);
    chk(kp == 8'h81, "R2", "control flag pattern", 64'(kp), 64'h81);
  endtask

  task automatic check_triple(input bit r2, input bit first, input string req);
    logic [63:0] s;
    logic [7:0]  kp;
    int          w;
    for (int c = 0; c < 3; c++) begin
      grab(s, kp, w);
      if (first && c == 0) chk(w == 1, "R2", "start delay after link up", 64'(w), 64'd1);
      cmp_pkt(s, kp, r2, c, req);
    end
  endtask

  // skip repeated round-1 packets, then expect one full round-2 triple and idle
  task automatic to_round2();
    logic [63:0] s;
    logic [7:0]  kp;
    int          w;
    bit          hit = 0;
    for (int p = 0; p < 8 && !hit; p++) begin
      grab(s, kp, w);
      if (s[15:8] == 8'hC0) hit = 1;
      else chk(s[15] == 1'b0, "R5", "only round-1 before round 2", 64'(s[15:8]), 64'h40);
    end
    chk(hit, "R5", "round-2 posted packet seen", 64'(hit), 64'd1);
    cmp_pkt(s, kp, 1'b1, 0, "R6");
    for (int c = 1; c < 3; c++) begin
      grab(s, kp, w);
      cmp_pkt(s, kp, 1'b1, c, "R6");
    end
    @(negedge clk);
    chk(fc_init == 1'b1, "R6", "fc_init after round 2", 64'(fc_init), 64'd1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(tx_k == 2'b00 && tx_data == 16'h0 && fc_init, "R6", "idle and held after done",
          {tx_k, tx_data, 7'd0, fc_init}, {18'h0, 7'd0, 1'b1});
    end
  endtask

  task automatic send_pkt(input logic [7:0] typ, input logic [7:0] h, input logic [11:0] d,
                          input bit bad_crc, input bit bad_end);
    logic [63:0] s;
    s = mk_pkt(typ, h, d);
    if (bad_crc) s[48] = ~s[48];
    if (bad_end) s[63:56] = 8'h00;
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      rx_data = s[16*b +: 16];
      rx_k    = (b == 0) ? 2'b01 : ((b == 3) ? 2'b10 : 2'b00);
    end
    @(negedge clk);
    rx_data = 16'h0;
    rx_k    = 2'b00;
  endtask

  task automatic check_peers(input logic [7:0] ph, input logic [11:0] pd,
                             input logic [7:0] nh, input logic [11:0] nd,
                             input logic [7:0] ch, input logic [11:0] cd, input string req);
    chk({peer_p_hdr, peer_p_data, peer_np_hdr, peer_np_data, peer_cpl_hdr, peer_cpl_data}
        == {ph, pd, nh, nd, ch, cd}, req, "partner credits",
        64'({peer_p_hdr, peer_p_data, peer_np_hdr, peer_np_data, peer_cpl_hdr, peer_cpl_data}),
        64'({ph, pd, nh, nd, ch, cd}));
  endtask

  task automatic set_defaults_expected();
    exp_hdr[0] = 8'd4; exp_dat[0] = 12'd64;
    exp_hdr[1] = 8'd4; exp_dat[1] = 12'd0;
    exp_hdr[2] = 8'd4; exp_dat[2] = 12'd64;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; link_up = 1'b0; cfg_use = 1'b0;
    cfg_p_hdr = '0; cfg_p_data = '0; cfg_np_hdr = '0;
    cfg_np_data = '0; cfg_cpl_hdr = '0; cfg_cpl_data = '0;
    rx_data = '0; rx_k = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(tx_k == 2'b00 && tx_data == 16'h0 && !fc_init, "R1", "idle in reset",
        {tx_k, tx_data, fc_init}, 64'h0);
    check_peers(0, 0, 0, 0, 0, 0, "R1");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(tx_k == 2'b00 && tx_data == 16'h0 && !fc_init, "R1", "idle while link down",
        {tx_k, tx_data, fc_init}, 64'h0);

    // vector table: R2 R3 R4 R5 R6 R7 R8
    foreach (VECS[v]) begin
      vec_t t;
      t = VECS[v];
      link_up = 1'b0;
      cfg_use = t.use_cfg;
      cfg_p_hdr = t.ph; cfg_p_data = t.pd;
      cfg_np_hdr = t.nh; cfg_np_data = t.nd;
      cfg_cpl_hdr = t.ch; cfg_cpl_data = t.cd;
      repeat (2) @(negedge clk);
      chk(tx_k == 2'b00 && !fc_init, "R10", "idle after link drop", {tx_k, fc_init}, 64'h0);
      check_peers(0, 0, 0, 0, 0, 0, "R10");
      if (t.use_cfg) begin
        exp_hdr[0] = t.ph; exp_dat[0] = t.pd;
        exp_hdr[1] = t.nh; exp_dat[1] = t.nd;
        exp_hdr[2] = t.ch; exp_dat[2] = t.cd;
      end else begin
        set_defaults_expected();
      end
      link_up = 1'b1;
      check_triple(1'b0, 1'b1, "R7");
      for (int r = 0; r < int'(t.extra); r++) check_triple(1'b0, 1'b0, "R5");
      send_pkt(8'h40, t.ph + 8'd3, t.pd + 12'd5, 0, 0);
      send_pkt(8'h50, t.nh + 8'd3, t.nd + 12'd5, 0, 0);
      send_pkt(8'h60, t.ch + 8'd3, t.cd + 12'd5, 0, 0);
      check_peers(t.ph + 8'd3, t.pd + 12'd5, t.nh + 8'd3, t.nd + 12'd5,
                  t.ch + 8'd3, t.cd + 12'd5, "R8");
      to_round2();
    end

    // directed: R9 bad CRC and missing end, R8 round-2 from partner counts
    link_up = 1'b0;
    cfg_use = 1'b0;
    set_defaults_expected();
    repeat (2) @(negedge clk);
    link_up = 1'b1;
    send_pkt(8'h40, 8'd7, 12'd77, 0, 0);
    check_peers(8'd7, 12'd77, 0, 0, 0, 0, "R8");
    send_pkt(8'h40, 8'd9, 12'd99, 1, 0);
    check_peers(8'd7, 12'd77, 0, 0, 0, 0, "R9");
    send_pkt(8'h50, 8'd9, 12'd99, 0, 1);
    check_peers(8'd7, 12'd77, 0, 0, 0, 0, "R9");
    send_pkt(8'hD0, 8'd3, 12'd30, 0, 0);
    send_pkt(8'hE0, 8'd5, 12'd50, 0, 0);
    check_peers(8'd7, 12'd77, 8'd3, 12'd30, 8'd5, 12'd50, "R8");
    to_round2();

    // R10: link drop clears, restarts from round 1
    @(negedge clk);
    link_up = 1'b0;
    @(negedge clk);
    chk(!fc_init && tx_k == 2'b00, "R10", "fc_init cleared", {fc_init, tx_k}, 64'h0);
    check_peers(0, 0, 0, 0, 0, 0, "R10");
    link_up = 1'b1;
    check_triple(1'b0, 1'b1, "R10");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule